// File: doc/BRIEF.md
# Memory Interface Calibration Command Sequencer

This block turns a 3-bit command, written by firmware, into the matching bring-up or calibration sequence on a memory interface cell. Firmware presents the command code and pulses `go_set`. That pulse is the write that raises the in-progress flag. The block then drives one-cycle start pulses to small calibration engines and waits for each engine's done strobe. When the operation finishes, it drops `busy` (the in-progress flag) on its own.

The initialization command runs automatic current calibration and then temperature calibration. After that it raises `sync_req` and holds there until an external clock-sync event arrives. When the event comes, it sets `init_done`. The block also enforces the bring-up order: initialization is accepted only after a completed power-up sequence, and only once. A reserved code, or an initialization request that breaks this order, is refused. A refused command raises `cmd_err`, leaves `busy` low and starts no engine.

Top module: `cal_cmd_seq`

## Requirements
- R1: After reset, `busy`, `sync_req`, `init_done`, `cmd_err` and every engine start output are 0.
- R2: A `go_set` pulse with a legal code, while `busy` is 0, sets `busy` on the next cycle and clears `cmd_err`.
- R3: Code 3'b000 (power-up) asserts `pwr_start` for exactly the cycle after acceptance. `busy` falls on the cycle after `pwr_done` is sampled high.
- R4: Code 3'b001 (initialization) pulses `acur_start`. The cycle after `acur_done` is sampled, it pulses `tcal_start`. The cycle after `tcal_done` is sampled, `sync_req` rises while `busy` stays 1.
- R5: While waiting for sync, a sampled `clk_sync_evt` clears `sync_req` and `busy` and sets `init_done` on the next cycle.
- R6: Code 3'b010 (manual current calibration) pulses `mcur_start`. `mcur_value` shows `cur_ctrl` as captured in the acceptance cycle and holds that value while the command runs.
- R7: Code 3'b011 (temperature calibration) pulses `tcal_start` alone. It finishes on `tcal_done` without raising `sync_req` or changing `init_done`, and is accepted whether or not power-up has run.
- R8: Codes 3'b100 to 3'b111 set `cmd_err` on the next cycle, leave `busy` at 0 and pulse no start output.
- R9: Code 3'b001 is refused in the same way as R8 if no power-up has completed since reset, or if an initialization has already completed.
- R10: A `go_set` pulse while `busy` is 1 is ignored: the running command completes unchanged and no extra start pulse follows.
- R11: Done strobes and `clk_sync_evt` that the current state is not waiting for have no effect on `busy`, `sync_req`, `init_done` or the start outputs.
- R12: At most one start output is high in any cycle, and each start pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_set | input | 1 | Firmware strobe that raises the in-progress flag for `cmd_code` |
| cmd_code | input | 3 | Command code |
| cur_ctrl | input | CUR_W | Programmed current-control value for manual calibration |
| pwr_start | output | 1 | Start pulse to the power-up/reset engine |
| pwr_done | input | 1 | Power-up engine finished |
| acur_start | output | 1 | Start pulse to the automatic current calibration engine |
| acur_done | input | 1 | Automatic current calibration finished |
| tcal_start | output | 1 | Start pulse to the temperature calibration engine |
| tcal_done | input | 1 | Temperature calibration finished |
| mcur_start | output | 1 | Start pulse to the manual current calibration engine |
| mcur_done | input | 1 | Manual current calibration finished |
| mcur_value | output | CUR_W | Current-control value loaded into the manual calibration |
| clk_sync_evt | input | 1 | Clock-sync event received |
| busy | output | 1 | In-progress flag |
| sync_req | output | 1 | Clock-sync requested |
| init_done | output | 1 | Initialization completed |
| cmd_err | output | 1 | Last command was refused |

## Verification
The bench builds the block with the default `CUR_W` of 6. This lets it present alternating bit patterns on `cur_ctrl` and then change them while a manual calibration runs, so a captured value can be told apart from a live one. Engine done strobes and the sync event come from bench tasks. Because of that, early, stray and late strobes can be placed in any state, including a long wait before the sync event arrives. The ordering guard is exercised from both sides: initialization before power-up, and initialization repeated after it has completed.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PWR, ST_ACUR, ST_TCAL, ST_MCUR, ST_SYNC
  } seq_state_t;

  typedef enum logic [2:0] {
    OP_PWR, OP_INIT, OP_MCUR, OP_TCAL, OP_NONE
  } seq_op_t;

  localparam int ENG_PWR  = 0;
  localparam int ENG_ACUR = 1;
  localparam int ENG_TCAL = 2;
  localparam int ENG_MCUR = 3;
  localparam int NUM_ENG  = 4;

  function automatic seq_op_t code_to_op(input logic [2:0] code);
    case (code)
      3'b000:  return OP_PWR;
      3'b001:  return OP_INIT;
      3'b010:  return OP_MCUR;
      3'b011:  return OP_TCAL;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic init_legal(input logic powered, input logic inited);
    return powered && !inited;
  endfunction

  function automatic seq_state_t entry_state(input seq_op_t op);
    case (op)
      OP_PWR:  return ST_PWR;
      OP_INIT: return ST_ACUR;
      OP_MCUR: return ST_MCUR;
      OP_TCAL: return ST_TCAL;
      default: return ST_IDLE;
    endcase
  endfunction

  function automatic logic [NUM_ENG-1:0] entry_start(input seq_op_t op);
    logic [NUM_ENG-1:0] v;
    v = '0;
    case (op)
      OP_PWR:  v[ENG_PWR]  = 1'b1;
      OP_INIT: v[ENG_ACUR] = 1'b1;
      OP_MCUR: v[ENG_MCUR] = 1'b1;
      OP_TCAL: v[ENG_TCAL] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cal_cmd_decode.sv
module cal_cmd_decode
  import cal_seq_pkg::*;
(
  input  logic [2:0] code,
  input  logic       powered,
  input  logic       inited,
  output seq_op_t    op,
  output logic       reject
);

  always_comb begin
    op     = code_to_op(code);
    reject = (op == OP_NONE) || ((op == OP_INIT) && !init_legal(powered, inited));
  end

endmodule

// File: rtl/cal_order_guard.sv
module cal_order_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_complete,
  input  logic init_complete,
  output logic powered,
  output logic inited
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      powered <= 1'b0;
      inited  <= 1'b0;
    end else begin
      if (pwr_complete)  powered <= 1'b1;
      if (init_complete) inited  <= 1'b1;
    end
  end

  // R9
  init_after_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_complete |-> powered);

  // R9
  init_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inited |-> !init_complete);

endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
  import cal_seq_pkg::*;
#(
  parameter int CUR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_set,
  input  seq_op_t             op,
  input  logic                reject,
  input  logic [CUR_W-1:0]    cur_ctrl,
  input  logic [NUM_ENG-1:0]  eng_done,
  input  logic                clk_sync_evt,
  output logic [NUM_ENG-1:0]  eng_start,
  output logic [CUR_W-1:0]    mcur_value,
  output logic                busy,
  output logic                sync_req,
  output logic                cmd_err,
  output logic                pwr_complete,
  output logic                init_complete
);

  seq_state_t state;
  logic       chain;
  logic       accept;
  logic       refuse;

  assign busy          = (state != ST_IDLE);
  assign accept        = go_set && !busy && !reject;
  assign refuse        = go_set && !busy && reject;
  assign pwr_complete  = (state == ST_PWR)  && eng_done[ENG_PWR];
  assign init_complete = (state == ST_SYNC) && clk_sync_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      eng_start  <= '0;
      mcur_value <= '0;
      sync_req   <= 1'b0;
      cmd_err    <= 1'b0;
      chain      <= 1'b0;
    end else begin
      eng_start <= '0;
      case (state)
        ST_IDLE: begin
          if (refuse) cmd_err <= 1'b1;
          if (accept) begin
            cmd_err   <= 1'b0;
            state     <= entry_state(op);
            eng_start <= entry_start(op);
            chain     <= (op == OP_INIT);
            if (op == OP_MCUR) mcur_value <= cur_ctrl;
          end
        end
        ST_PWR:  if (eng_done[ENG_PWR])  state <= ST_IDLE;
        ST_MCUR: if (eng_done[ENG_MCUR]) state <= ST_IDLE;
        ST_ACUR: begin
          if (eng_done[ENG_ACUR]) begin
            state               <= ST_TCAL;
            eng_start[ENG_TCAL] <= 1'b1;
          end
        end
        ST_TCAL: begin
          if (eng_done[ENG_TCAL]) begin
            if (chain) begin
              state    <= ST_SYNC;
              sync_req <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_SYNC: begin
          if (clk_sync_evt) begin
            state    <= ST_IDLE;
            sync_req <= 1'b0;
            chain    <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NUM_ENG; g++) begin : g_pulse
      // R12
      start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start[g] |=> !eng_start[g]);
    end
  endgenerate

  // R12
  one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_start));

  // R5
  sync_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |-> busy);

  // R5
  sync_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_complete |=> (!sync_req && !busy));

  // R8
  reject_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> (cmd_err && !busy && (eng_start == '0)));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !cmd_err));

  // R6
  mcur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MCUR) |=> $stable(mcur_value));

endmodule

// File: rtl/cal_cmd_seq.sv
module cal_cmd_seq
  import cal_seq_pkg::*;
#(
  parameter int CUR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_set,
  input  logic [2:0]       cmd_code,
  input  logic [CUR_W-1:0] cur_ctrl,
  output logic             pwr_start,
  input  logic             pwr_done,
  output logic             acur_start,
  input  logic             acur_done,
  output logic             tcal_start,
  input  logic             tcal_done,
  output logic             mcur_start,
  input  logic             mcur_done,
  output logic [CUR_W-1:0] mcur_value,
  input  logic             clk_sync_evt,
  output logic             busy,
  output logic             sync_req,
  output logic             init_done,
  output logic             cmd_err
);

  seq_op_t            dec_op;
  logic               dec_reject;
  logic               powered;
  logic               inited;
  logic               pwr_complete;
  logic               init_complete;
  logic [NUM_ENG-1:0] eng_start;
  logic [NUM_ENG-1:0] eng_done;

  always_comb begin
    eng_done           = '0;
    eng_done[ENG_PWR]  = pwr_done;
    eng_done[ENG_ACUR] = acur_done;
    eng_done[ENG_TCAL] = tcal_done;
    eng_done[ENG_MCUR] = mcur_done;
  end

  assign pwr_start  = eng_start[ENG_PWR];
  assign acur_start = eng_start[ENG_ACUR];
  assign tcal_start = eng_start[ENG_TCAL];
  assign mcur_start = eng_start[ENG_MCUR];
  assign init_done  = inited;

  cal_cmd_decode u_decode (
    .code    (cmd_code),
    .powered (powered),
    .inited  (inited),
    .op      (dec_op),
    .reject  (dec_reject)
  );

  cal_order_guard u_guard (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_complete  (pwr_complete),
    .init_complete (init_complete),
    .powered       (powered),
    .inited        (inited)
  );

  cal_seq_fsm #(.CUR_W(CUR_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .go_set        (go_set),
    .op            (dec_op),
    .reject        (dec_reject),
    .cur_ctrl      (cur_ctrl),
    .eng_done      (eng_done),
    .clk_sync_evt  (clk_sync_evt),
    .eng_start     (eng_start),
    .mcur_value    (mcur_value),
    .busy          (busy),
    .sync_req      (sync_req),
    .cmd_err       (cmd_err),
    .pwr_complete  (pwr_complete),
    .init_complete (init_complete)
  );

  // R11
  idle_stray_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go_set) |=> (!busy && !sync_req));

endmodule

// File: tb/cal_cmd_seq_bench.sv
`timescale 1ns/1ps
module cal_cmd_seq_bench;

  localparam int CUR_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             go_set = 1'b0;
  logic [2:0]       cmd_code = 3'b000;
  logic [CUR_W-1:0] cur_ctrl = '0;
  logic             pwr_done = 1'b0, acur_done = 1'b0, tcal_done = 1'b0, mcur_done = 1'b0;
  logic             clk_sync_evt = 1'b0;
  logic             pwr_start, acur_start, tcal_start, mcur_start;
  logic [CUR_W-1:0] mcur_value;
  logic             busy, sync_req, init_done, cmd_err;

  int n_cmp = 0;
  int n_bad = 0;
  int r12_viol = 0;
  logic [3:0] prev_starts = '0;

  always #10 clk = ~clk;

  cal_cmd_seq #(.CUR_W(CUR_W)) u_cal_cmd_seq (
    .clk(clk), .rst_n(rst_n), .go_set(go_set), .cmd_code(cmd_code), .cur_ctrl(cur_ctrl),
    .pwr_start(pwr_start), .pwr_done(pwr_done), .acur_start(acur_start), .acur_done(acur_done),
    .tcal_start(tcal_start), .tcal_done(tcal_done), .mcur_start(mcur_start), .mcur_done(mcur_done),
    .mcur_value(mcur_value), .clk_sync_evt(clk_sync_evt), .busy(busy), .sync_req(sync_req),
    .init_done(init_done), .cmd_err(cmd_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] starts();
    return {mcur_start, tcal_start, acur_start, pwr_start};
  endfunction

  // R12 monitor: one start at a time, one cycle each
  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(starts()) > 1) r12_viol++;
      if ((starts() & prev_starts) != 4'b0) r12_viol++;
      prev_starts <= starts();
    end
  end

  task automatic go(input logic [2:0] code);
    go_set = 1'b1;
    cmd_code = code;
    @(negedge clk);
    go_set = 1'b0;
  endtask

  task automatic strobe(input int which);
    case (which)
      0: pwr_done = 1'b1;
      1: acur_done = 1'b1;
      2: tcal_done = 1'b1;
      3: mcur_done = 1'b1;
      default: clk_sync_evt = 1'b1;
    endcase
    @(negedge clk);
    pwr_done = 1'b0; acur_done = 1'b0; tcal_done = 1'b0; mcur_done = 1'b0;
    clk_sync_evt = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 sync_req", sync_req, 0);
    chk("R1 init_done", init_done, 0);
    chk("R1 cmd_err", cmd_err, 0);
    chk("R1 starts", starts(), 0);
  endtask

  task automatic t_early_init();
    go(3'b001);
    chk("R9 err before power-up", cmd_err, 1);
    chk("R9 busy before power-up", busy, 0);
    chk("R9 no start", starts(), 0);
  endtask

  task automatic t_reserved();
    for (int c = 4; c < 8; c++) begin
      go(3'(c));
      chk("R8 err", cmd_err, 1);
      chk("R8 busy", busy, 0);
      chk("R8 no start", starts(), 0);
    end
  endtask

  task automatic t_tcal_alone();
    go(3'b011);
    chk("R2 err cleared", cmd_err, 0);
    chk("R7 tcal_start", starts(), 4'b0100);
    chk("R7 busy", busy, 1);
    strobe(4);
    strobe(1);
    chk("R11 stray sync/acur keeps busy", busy, 1);
    chk("R11 stray sync no req", sync_req, 0);
    strobe(2);
    chk("R7 busy cleared", busy, 0);
    chk("R7 no sync_req", sync_req, 0);
    chk("R7 init_done unchanged", init_done, 0);
  endtask

  task automatic t_powerup();
    strobe(0);
    chk("R11 stray pwr_done idle", busy, 0);
    go(3'b000);
    chk("R3 pwr_start", starts(), 4'b0001);
    chk("R2 busy", busy, 1);
    @(negedge clk);
    chk("R3 pulse one cycle", pwr_start, 0);
    go(3'b011);
    chk("R10 busy-time go ignored", tcal_start, 0);
    chk("R10 still busy", busy, 1);
    strobe(0);
    chk("R3 busy cleared", busy, 0);
    @(negedge clk);
    chk("R10 no late start", starts(), 0);
    chk("R10 idle", busy, 0);
  endtask

  task automatic t_mcur();
    cur_ctrl = 6'h2A;
    go(3'b010);
    cur_ctrl = 6'h15;
    chk("R6 mcur_start", starts(), 4'b1000);
    chk("R6 value captured", mcur_value, 'h2A);
    repeat (3) @(negedge clk);
    chk("R6 value held", mcur_value, 'h2A);
    chk("R6 busy", busy, 1);
    strobe(3);
    chk("R6 busy cleared", busy, 0);
  endtask

  task automatic t_init();
    go(3'b001);
    chk("R4 acur_start", starts(), 4'b0010);
    chk("R4 busy", busy, 1);
    strobe(2);
    strobe(4);
    chk("R11 stray in acur no tcal", tcal_start, 0);
    chk("R11 stray in acur no req", sync_req, 0);
    chk("R11 stray in acur busy", busy, 1);
    strobe(1);
    chk("R4 tcal_start after acur_done", starts(), 4'b0100);
    strobe(2);
    chk("R4 sync_req", sync_req, 1);
    chk("R4 busy during sync", busy, 1);
    chk("R4 init_done not yet", init_done, 0);
    strobe(2);
    repeat (5) @(negedge clk);
    chk("R11 waiting sync holds", sync_req, 1);
    strobe(4);
    chk("R5 sync_req cleared", sync_req, 0);
    chk("R5 init_done", init_done, 1);
    chk("R5 busy cleared", busy, 0);
  endtask

  task automatic t_init_again();
    go(3'b001);
    chk("R9 err on second init", cmd_err, 1);
    chk("R9 busy on second init", busy, 0);
    chk("R9 no start second init", starts(), 0);
    chk("R9 init_done kept", init_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_early_init();
    t_reserved();
    t_tcal_alone();
    t_powerup();
    t_mcur();
    t_init();
    t_init_again();
    repeat (2) @(negedge clk);
    chk("R12 start pulse violations", r12_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule